// File: doc/BRIEF.md
# Unaligned Store Splitter

This block sits between a processor's store path and a 64-bit system bus. It takes one cache-inhibited store of a byte, a halfword or a word at any byte address. It turns that store into one or two single-beat bus writes. Each beat carries a doubleword-aligned address, 64 bits of data and eight byte enables.

The store data is rotated so that its first byte sits in the 32-bit lane selected by the low two address bits. Halfword and byte data is first repeated to fill 32 bits. The rotated pattern is then copied onto both halves of the 64-bit bus. When the store's bytes reach past the end of a doubleword, the block issues a second beat for the next doubleword. That beat carries the same data pattern and only the enables of the remaining bytes. It is issued once the bus has acknowledged the first beat.

Top module: `unaligned_store_splitter`

## Requirements
- R1: After synchronous reset, and in the cycle after any reset, `beat_valid` and `req_busy` are both low.
- R2: A store is taken when `req_valid` is high and `req_busy` is low. In the next cycle `beat_valid` and `req_busy` are high. A request raised while `req_busy` is high is ignored and produces no beat.
- R3: The data pattern is rotated so that store byte k lands in 32-bit lane (addr mod 4 + k) mod 4. Byte 0 is the most significant byte, and lane 0 is bits 31:24. For example, word E02D0043 at an address ending in 7 becomes 2D0043E0.
- R4: `beat_data[63:32]` equals `beat_data[31:0]` in every beat, including lanes whose enables are off.
- R5: `req_size` encodes 0 = byte, taken from `req_data[7:0]`; 1 = halfword, taken from `req_data[15:0]`; 2 = word. Byte and halfword data is repeated to 32 bits before rotation. Unused upper data bits have no effect.
- R6: `beat_be[i]` enables bus byte i, where byte 0 is `beat_data[63:56]`. Each beat enables exactly the store's bytes that fall inside its doubleword.
- R7: A store whose bytes stay inside one doubleword produces exactly one beat. This includes a store that crosses a word boundary, such as a word at offset 3.
- R8: A store that crosses a doubleword boundary produces two beats. The first beat is at the store address with bits 2:0 cleared, and the second beat is 8 bytes higher.
- R9: A beat's address, data and enables hold steady until `beat_ack`. The second beat appears only in the cycle after the first beat is acknowledged. `req_busy` stays high until the last beat is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Store request present |
| req_addr | input | ADDR_W | Byte address of the store |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_data | input | 32 | Store data, right-justified |
| req_busy | output | 1 | Store in progress; new requests are ignored |
| beat_valid | output | 1 | Bus write beat presented |
| beat_addr | output | ADDR_W | Doubleword-aligned beat address |
| beat_data | output | 64 | Beat data, rotated pattern on both halves |
| beat_be | output | 8 | Byte enables, bit i for byte i from the MSB |
| beat_ack | input | 1 | Bus accepts the presented beat |

## Verification
The bench targets the points where the doubleword boundary decides the beat count. These are word stores at offsets 5, 6 and 7 and a halfword at offset 7, which must split. Stores at offset 3 cross only a word boundary and must not split. A design that compared against a word boundary would emit a spurious second beat, and one that ignored the crossing would drop the trailing bytes. Rotation is checked at every lane offset with distinct bytes, so a rotation in the wrong direction shows up as a swapped pattern. Halfword and byte stores carry junk in the unused data bits, so a missing replication or mask is caught. Ack is delayed by varying amounts and a request is raised during a busy transfer, which catches beats that change before ack and second beats that run ahead.

// File: rtl/usp_pkg.sv
package usp_pkg;
  localparam int BUS_BYTES  = 8;
  localparam int LANE_BYTES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } store_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } split_state_e;
endpackage

// File: rtl/usp_lane_rotate.sv
module usp_lane_rotate
  import usp_pkg::*;
#(
  parameter int LANES = LANE_BYTES
) (
  input  logic [8*LANES-1:0]         data_in,
  input  logic [1:0]                 size,
  input  logic [$clog2(LANES)-1:0]   rot,
  output logic [8*LANES-1:0]         pattern
);
  localparam int ROT_W = $clog2(LANES);
  localparam int W     = 8 * LANES;

  logic [W-1:0] repl;
  logic [7:0]   src_b [LANES];

  // replicate narrow stores so every lane holds valid store bytes
  always_comb begin
    case (size)
      SZ_BYTE: repl = {(LANES){data_in[7:0]}};
      SZ_HALF: repl = {(LANES/2){data_in[15:0]}};
      default: repl = data_in;
    endcase
  end

  genvar j;
  generate
    for (j = 0; j < LANES; j++) begin : g_lane
      logic [ROT_W-1:0] src;
      assign src_b[j] = repl[W-1-8*j -: 8];
      assign src      = ROT_W'(j) - rot;
      assign pattern[W-1-8*j -: 8] = src_b[src];
    end
  endgenerate
endmodule

// File: rtl/usp_beat_plan.sv
module usp_beat_plan
  import usp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NBYTES = BUS_BYTES
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] base_addr,
  output logic [NBYTES-1:0] be_first,
  output logic [NBYTES-1:0] be_second,
  output logic              two_beats
);
  localparam int OFF_W = $clog2(NBYTES);

  logic [OFF_W-1:0]    start;
  int                  len;
  logic [2*NBYTES-1:0] window;

  assign start     = addr[OFF_W-1:0];
  assign base_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_comb begin
    case (size)
      SZ_BYTE: len = 1;
      SZ_HALF: len = 2;
      default: len = 4;
    endcase
  end

  genvar j;
  generate
    for (j = 0; j < 2*NBYTES; j++) begin : g_win
      assign window[j] = (j >= int'(start)) && (j < int'(start) + len);
    end
  endgenerate

  assign be_first  = window[NBYTES-1:0];
  assign be_second = window[2*NBYTES-1:NBYTES];
  assign two_beats = (int'(start) + len) > NBYTES;
endmodule

// File: rtl/unaligned_store_splitter.sv
module unaligned_store_splitter
  import usp_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_data,
  output logic              req_busy,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [63:0]       beat_data,
  output logic [7:0]        beat_be,
  input  logic              beat_ack
);
  localparam int COPIES = BUS_BYTES / LANE_BYTES;
  localparam int ROT_W  = $clog2(LANE_BYTES);

  logic [8*LANE_BYTES-1:0] pattern;
  logic [ADDR_W-1:0]       base;
  logic [BUS_BYTES-1:0]    be0, be1, be1_q;
  logic                    two, two_q;
  split_state_e            st;

  usp_lane_rotate #(.LANES(LANE_BYTES)) u_rot (
    .data_in (req_data),
    .size    (req_size),
    .rot     (req_addr[ROT_W-1:0]),
    .pattern (pattern)
  );

  usp_beat_plan #(.ADDR_W(ADDR_W), .NBYTES(BUS_BYTES)) u_plan (
    .addr      (req_addr),
    .size      (req_size),
    .base_addr (base),
    .be_first  (be0),
    .be_second (be1),
    .two_beats (two)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      beat_valid <= 1'b0;
      beat_addr  <= '0;
      beat_data  <= '0;
      beat_be    <= '0;
      be1_q      <= '0;
      two_q      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          st         <= ST_FIRST;
          beat_valid <= 1'b1;
          beat_addr  <= base;
          beat_data  <= {COPIES{pattern}};
          beat_be    <= be0;
          be1_q      <= be1;
          two_q      <= two;
        end
        ST_FIRST: if (beat_ack) begin
          if (two_q) begin
            st        <= ST_SECOND;
            beat_addr <= beat_addr + ADDR_W'(BUS_BYTES);
            beat_be   <= be1_q;
          end else begin
            st         <= ST_IDLE;
            beat_valid <= 1'b0;
          end
        end
        ST_SECOND: if (beat_ack) begin
          st         <= ST_IDLE;
          beat_valid <= 1'b0;
        end
        default: begin
          st         <= ST_IDLE;
          beat_valid <= 1'b0;
        end
      endcase
    end
  end

  assign req_busy = (st != ST_IDLE);
endmodule

// File: rtl/usp_checker.sv
module usp_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_busy,
  input logic              beat_valid,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [63:0]       beat_data,
  input logic [7:0]        beat_be,
  input logic              beat_ack
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !req_busy |-> !beat_valid);

  p_halves_equal_r4: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_data[63:32] == beat_data[31:0]));

  p_be_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_be != 8'h00));

  p_addr_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_addr[2:0] == 3'b000));

  p_next_dword_r8: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ack) |=>
      (!beat_valid || (beat_addr == $past(beat_addr) + ADDR_W'(8))));

  p_second_leads_r6: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ack) |=> (!beat_valid || beat_be[0]));

  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ack) |=>
      (beat_valid && $stable(beat_addr) && $stable(beat_data) && $stable(beat_be)));
endmodule

bind unaligned_store_splitter usp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_busy   (req_busy),
  .beat_valid (beat_valid),
  .beat_addr  (beat_addr),
  .beat_data  (beat_data),
  .beat_be    (beat_be),
  .beat_ack   (beat_ack)
);

// File: tb/unaligned_store_splitter_tb.sv
module unaligned_store_splitter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_data = '0;
  logic        req_busy, beat_valid, beat_ack;
  logic [31:0] beat_addr;
  logic [63:0] beat_data;
  logic [7:0]  beat_be;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  unaligned_store_splitter #(.ADDR_W(32)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_data(req_data), .req_busy(req_busy),
    .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_data(beat_data),
    .beat_be(beat_be), .beat_ack(beat_ack)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [31:0] data;
    logic        two;
    logic [7:0]  be0;
    logic [7:0]  be1;
    logic [31:0] pat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 2'd2, 32'h1234_5678, 1'b0, 8'h0F, 8'h00, 32'h1234_5678},
    '{32'h0000_1004, 2'd2, 32'h1234_5678, 1'b0, 8'hF0, 8'h00, 32'h1234_5678},
    '{32'hC01C_5557, 2'd2, 32'hE02D_0043, 1'b1, 8'h80, 8'h07, 32'h2D00_43E0},
    '{32'h0000_2003, 2'd2, 32'hAABB_CCDD, 1'b0, 8'h78, 8'h00, 32'hBBCC_DDAA},
    '{32'h0000_2005, 2'd2, 32'h1122_3344, 1'b1, 8'hE0, 8'h01, 32'h4411_2233},
    '{32'h0000_2006, 2'd2, 32'h1122_3344, 1'b1, 8'hC0, 8'h03, 32'h3344_1122},
    '{32'h0000_300A, 2'd1, 32'h9876_BEEF, 1'b0, 8'h0C, 8'h00, 32'hBEEF_BEEF},
    '{32'h0000_300F, 2'd1, 32'h5555_CAFE, 1'b1, 8'h80, 8'h01, 32'hFECA_FECA},
    '{32'h0000_3003, 2'd1, 32'hAAAA_CAFE, 1'b0, 8'h18, 8'h00, 32'hFECA_FECA},
    '{32'h0000_4005, 2'd0, 32'h1234_565A, 1'b0, 8'h20, 8'h00, 32'h5A5A_5A5A},
    '{32'h0000_4007, 2'd0, 32'hFFFF_FFA5, 1'b0, 8'h80, 8'h00, 32'hA5A5_A5A5},
    '{32'h0000_4001, 2'd1, 32'hDEAD_1234, 1'b0, 8'h06, 8'h00, 32'h3412_3412}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ack(input int delay);
    for (int d = 0; d < delay; d++) @(negedge clk);
    beat_ack = 1'b1;
    @(negedge clk);
    beat_ack = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int delay);
    logic [31:0] base;
    base = {v.addr[31:3], 3'b000};
    @(negedge clk);
    req_valid = 1'b1; req_addr = v.addr; req_size = v.size; req_data = v.data;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 first beat valid", 64'(beat_valid), 64'd1);
    check("R9 busy during beat", 64'(req_busy), 64'd1);
    check("R8 first beat addr", 64'(beat_addr), 64'(base));
    check("R3/R4/R5 beat data", beat_data, {v.pat, v.pat});
    check("R6 first beat enables", 64'(beat_be), 64'(v.be0));
    if (delay > 0) begin
      for (int d = 0; d < delay; d++) @(negedge clk);
      check("R9 held before ack addr", 64'(beat_addr), 64'(base));
      check("R9 held before ack be", 64'(beat_be), 64'(v.be0));
    end
    wait_ack(0);
    if (v.two) begin
      check("R8 second beat valid", 64'(beat_valid), 64'd1);
      check("R8 second beat addr", 64'(beat_addr), 64'(base + 32'd8));
      check("R6 second beat enables", 64'(beat_be), 64'(v.be1));
      check("R4 second beat data", beat_data, {v.pat, v.pat});
      check("R9 busy until last ack", 64'(req_busy), 64'd1);
      wait_ack(delay);
    end
    check("R7 no extra beat", 64'(beat_valid), 64'd0);
    check("R9 idle after last ack", 64'(req_busy), 64'd0);
  endtask

  initial begin : watchdog
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    beat_ack = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(beat_valid), 64'd0);
    check("R1 reset busy", 64'(req_busy), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3);

    // R2: a request while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h1000; req_size = 2'd2; req_data = 32'h0;
    @(negedge clk);
    req_addr = 32'h5000; req_data = 32'hFFFF_FFFF;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 busy request ignored addr", 64'(beat_addr), 64'h1000);
    check("R2 busy request ignored data", beat_data, 64'h0);
    wait_ack(1);
    check("R2 no beat for ignored store", 64'(beat_valid), 64'd0);
    @(negedge clk);
    check("R2 still idle later", 64'(beat_valid), 64'd0);

    // R1: reset in the middle of a split store
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h2007; req_size = 2'd2; req_data = 32'h0102_0304;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-store reset valid", 64'(beat_valid), 64'd0);
    check("R1 mid-store reset busy", 64'(req_busy), 64'd0);

    run_vec(VECS[2], 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule